// File: doc/BRIEF.md
# Clock Output Stop Controller

This block sits at the output stage of a clock buffer. It decides, for every differential output pair, what each side of the pair does: toggle, hold high, or float. The pair's toggling is modelled by a phase register that is derived from the reference clock. The block takes an asynchronous active-low stop request and synchronizes it to the reference clock. It stops the pairs only on a clean boundary and parks them in a state that a configuration bit selects. When the request is withdrawn, it restarts them on a boundary that gives a full-width first pulse.

The output frequency is the reference clock divided by `2*HALF_CYC`. The true side of a running pair follows the phase register `ph`, and the complement side is its inverse. A complement rising edge is the clock cycle in which `ph` goes from 1 to 0. A complement falling edge is the cycle in which `ph` goes from 0 to 1. Each pair has four outputs: a value and an output enable for each side. An enable of 0 means that side floats. Analog current levels and the PLL are outside this block. All pins are plain control pins, because no data stream passes through the block.

Top module: `clkstop_ctrl`

## Requirements
- R1: `pd_req_n` passes through `SYNC_STAGES` reset-cleared flops before any use. Reset clears these flops to 0, which means "stop requested", so no pair leaves the parked state during the first `SYNC_STAGES` cycles after reset.
- R2: A stop is taken only when the synchronized request is low at `STOP_SAMPLES` (default 2) consecutive complement rising edges. A single high sample restarts that count.
- R3: Once a stop is taken, the pairs park at the next complement falling edge, which is the cycle where true rises. Every driven low phase of a true output therefore lasts exactly `HALF_CYC` cycles.
- R4: With `park_float`=0, a parked pair drives its true side to 1 (`true_oe`=1, `true_val`=1) and floats its complement side (`comp_oe`=0).
- R5: With `park_float`=1, a parked pair floats both sides (`true_oe`=0, `comp_oe`=0).
- R6: With `park_float`=1, after the request is withdrawn, each enabled pair drives both sides to 1 until it restarts. If the request returns during this time, the block goes back to the stopped state.
- R7: A restart after withdrawal begins only at a complement falling edge, so the first restored true pulse is full width.
- R8: `out_en[i]`=0 keeps pair i parked (as set by R4/R5) whatever the request does. Changes to `out_en` take effect only at complement falling edges.
- R9: While reset is asserted, every pair is parked as set by R4/R5, and `ph` is 1.
- R10: While running, each enabled pair drives both sides with true = `ph` and complement = not `ph`. `ph` toggles every `HALF_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low stop request |
| park_float | input | 1 | Parking style: 0 = true held high and complement floating, 1 = both sides floating |
| out_en | input | N_OUT | Per-pair enable |
| true_val_o | output | N_OUT | True-side drive value |
| true_oe_o | output | N_OUT | True-side drive enable |
| comp_val_o | output | N_OUT | Complement-side drive value |
| comp_oe_o | output | N_OUT | Complement-side drive enable |

## Verification
The bench builds the block with N_OUT=3, SYNC_STAGES=3, HALF_CYC=2 and STOP_SAMPLES=2. With HALF_CYC=2, the complement edge events fall on only some cycles, so a stop or restart placed on the wrong cycle produces a visible runt low phase. Three synchronizer stages make the reset-to-wake latency long enough to count. Three pairs with random enables let parked, disabled and running pairs appear side by side, while the request pulses and the parking-style changes are random.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_STOP = 2'd2,
    ST_WAKE = 2'd3
  } stop_st_e;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_async,
  output logic req_n_sync
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], req_n_async};
  end

  assign req_n_sync = sh[STAGES-1];

  AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    req_n_sync == $past(sh[STAGES-2])); // R1
endmodule

// File: rtl/clkstop_phase.sv
module clkstop_phase #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ph,
  output logic comp_rise,
  output logic comp_fall
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int RW = $clog2(HALF_CYC + 1) + 1;

  logic [CW-1:0] hcnt;
  logic          last;

  assign last      = (hcnt == CW'(HALF_CYC - 1));
  assign comp_rise = last & ph;
  assign comp_fall = last & ~ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      ph   <= 1'b1;
    end else if (last) begin
      hcnt <= '0;
      ph   <= ~ph;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // run-length monitor for the half period
  logic          ph_d;
  logic [RW-1:0] run_c;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_d  <= 1'b1;
      run_c <= '0;
    end else begin
      ph_d  <= ph;
      run_c <= (ph != ph_d) ? RW'(1) : run_c + 1'b1;
    end
  end

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != ph_d) |-> (run_c == RW'(HALF_CYC))); // R10
endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
  import clkstop_pkg::*;
#(
  parameter int STOP_SAMPLES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pd_ok,
  input  logic     comp_rise,
  input  logic     comp_fall,
  input  logic     ph,
  output stop_st_e st
);
  localparam int LW = $clog2(STOP_SAMPLES + 1);

  stop_st_e      nxt;
  logic [LW-1:0] lowcnt;
  logic          qual_done;

  assign qual_done = comp_rise & ~pd_ok & (lowcnt == LW'(STOP_SAMPLES - 1));

  always_comb begin
    nxt = st;
    unique case (st)
      ST_RUN:  if (qual_done) nxt = ST_PEND;
      ST_PEND: if (comp_fall) nxt = ST_STOP;
      ST_STOP: if (pd_ok) nxt = ST_WAKE;
      ST_WAKE: begin
        if (!pd_ok)         nxt = ST_STOP;
        else if (comp_fall) nxt = ST_RUN;
      end
      default: nxt = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_STOP;
      lowcnt <= '0;
    end else begin
      st <= nxt;
      if (st != ST_RUN) lowcnt <= '0;
      else if (comp_rise) begin
        if (pd_ok)                                   lowcnt <= '0;
        else if (lowcnt != LW'(STOP_SAMPLES - 1))    lowcnt <= lowcnt + 1'b1;
      end
    end
  end

  AST_LOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && comp_rise && pd_ok) |=> (lowcnt == '0)); // R2
  AST_QUAL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PEND && $past(st) == ST_RUN) |-> ($past(comp_rise) && !$past(pd_ok))); // R2
  AST_STOP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && $past(st) == ST_PEND) |-> (ph && !$past(ph))); // R3
  AST_RESTART_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && $past(st) == ST_WAKE) |-> (ph && !$past(ph))); // R7
  AST_WAKE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAKE && !pd_ok) |=> (st == ST_STOP)); // R6
endmodule

// File: rtl/clkstop_drive.sv
module clkstop_drive
  import clkstop_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stop_st_e         st,
  input  logic             ph,
  input  logic             comp_fall,
  input  logic             park_float,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] true_val_o,
  output logic [N_OUT-1:0] true_oe_o,
  output logic [N_OUT-1:0] comp_val_o,
  output logic [N_OUT-1:0] comp_oe_o
);
  logic [N_OUT-1:0] en_q;
  logic             running;
  logic             waking;

  assign running = (st == ST_RUN) || (st == ST_PEND);
  assign waking  = (st == ST_WAKE) && park_float;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (comp_fall) en_q <= out_en;
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_pair
    always_comb begin
      if (en_q[i] && running) begin
        true_val_o[i] = ph;   true_oe_o[i] = 1'b1;
        comp_val_o[i] = ~ph;  comp_oe_o[i] = 1'b1;
      end else if (en_q[i] && waking) begin
        true_val_o[i] = 1'b1; true_oe_o[i] = 1'b1;
        comp_val_o[i] = 1'b1; comp_oe_o[i] = 1'b1;
      end else if (!park_float) begin
        true_val_o[i] = 1'b1; true_oe_o[i] = 1'b1;
        comp_val_o[i] = 1'b0; comp_oe_o[i] = 1'b0;
      end else begin
        true_val_o[i] = 1'b0; true_oe_o[i] = 1'b0;
        comp_val_o[i] = 1'b0; comp_oe_o[i] = 1'b0;
      end
    end

    AST_DISABLED_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |-> (!comp_oe_o[i] && (true_oe_o[i] == !park_float))); // R8
  end

  AST_EN_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != $past(en_q)) |-> (ph && !$past(ph))); // R8
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_OUT        = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int HALF_CYC     = 2,
  parameter int STOP_SAMPLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req_n,
  input  logic             park_float,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] true_val_o,
  output logic [N_OUT-1:0] true_oe_o,
  output logic [N_OUT-1:0] comp_val_o,
  output logic [N_OUT-1:0] comp_oe_o
);
  logic     pd_ok;
  logic     ph;
  logic     comp_rise;
  logic     comp_fall;
  stop_st_e st;

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_n_async(pd_req_n), .req_n_sync(pd_ok));

  clkstop_phase #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .ph(ph), .comp_rise(comp_rise), .comp_fall(comp_fall));

  clkstop_fsm #(.STOP_SAMPLES(STOP_SAMPLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_ok(pd_ok), .comp_rise(comp_rise),
    .comp_fall(comp_fall), .ph(ph), .st(st));

  clkstop_drive #(.N_OUT(N_OUT)) u_drive (
    .clk(clk), .rst_n(rst_n), .st(st), .ph(ph), .comp_fall(comp_fall),
    .park_float(park_float), .out_en(out_en),
    .true_val_o(true_val_o), .true_oe_o(true_oe_o),
    .comp_val_o(comp_val_o), .comp_oe_o(comp_oe_o));

  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && !park_float) |->
      (true_oe_o == '1 && true_val_o == '1 && comp_oe_o == '0)); // R4
  AST_PARK_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && park_float) |-> (true_oe_o == '0 && comp_oe_o == '0)); // R5
  AST_WAKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAKE && park_float) |->
      ((true_oe_o & ~true_val_o) == '0 && (comp_oe_o & ~comp_val_o) == '0
       && comp_oe_o == true_oe_o)); // R6
endmodule

// File: tb/clkstop_ctrl_test.sv
module clkstop_ctrl_test;
  localparam int N    = 3;
  localparam int SYNC = 3;
  localparam int HALF = 2;
  localparam int SAMP = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pd_req_n = 1'b1;
  logic         park_float = 1'b0;
  logic [N-1:0] out_en = '1;
  logic [N-1:0] true_val_o, true_oe_o, comp_val_o, comp_oe_o;

  int n_vec = 0;
  int n_bad = 0;

  clkstop_ctrl #(.N_OUT(N), .SYNC_STAGES(SYNC), .HALF_CYC(HALF), .STOP_SAMPLES(SAMP)) uut (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .park_float(park_float),
    .out_en(out_en), .true_val_o(true_val_o), .true_oe_o(true_oe_o),
    .comp_val_o(comp_val_o), .comp_oe_o(comp_oe_o));

  always #4 clk = ~clk;

  // reference model: 0 run, 1 pending, 2 stopped, 3 waking
  logic [SYNC-1:0] m_sh;
  logic            m_ph;
  int              m_hcnt, m_st, m_low;
  logic [N-1:0]    m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sh = '0; m_ph = 1'b1; m_hcnt = 0; m_st = 2; m_low = 0; m_en = '0;
    end else begin
      logic ok, last, rise, fall;
      int nst;
      ok = m_sh[SYNC-1];
      last = (m_hcnt == HALF - 1);
      rise = last && m_ph;
      fall = last && !m_ph;
      nst = m_st;
      case (m_st)
        0: if (rise && !ok && m_low == SAMP - 1) nst = 1;
        1: if (fall) nst = 2;
        2: if (ok) nst = 3;
        default: if (!ok) nst = 2; else if (fall) nst = 0;
      endcase
      if (m_st != 0) m_low = 0;
      else if (rise) m_low = ok ? 0 : ((m_low < SAMP - 1) ? m_low + 1 : m_low);
      if (fall) m_en = out_en;
      m_sh = {m_sh[SYNC-2:0], pd_req_n};
      if (last) begin m_hcnt = 0; m_ph = !m_ph; end
      else m_hcnt = m_hcnt + 1;
      m_st = nst;
    end
  end

  function automatic logic [3:0] park_val();
    return park_float ? 4'b0000 : 4'b1100;
  endfunction

  function automatic logic [3:0] exp_pair(int i);
    if (m_en[i] && (m_st == 0 || m_st == 1)) return {m_ph, 1'b1, !m_ph, 1'b1};
    if (m_en[i] && m_st == 3 && park_float) return 4'b1111;
    return park_val();
  endfunction

  function automatic string req_of(int i);
    if (!m_en[i]) return "R8";
    case (m_st)
      0: return "R10";
      1: return "R3";
      2: return park_float ? "R5" : "R4";
      default: return park_float ? "R6" : "R4";
    endcase
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: {tv,toe,cv,coe} actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic [3:0] act_pair(int i);
    return {true_val_o[i], true_oe_o[i], comp_val_o[i], comp_oe_o[i]};
  endfunction

  // per-cycle comparison against the model
  int prev_st = 2;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++)
        check((prev_st == 3 && m_st == 0) ? "R7" : req_of(i), act_pair(i), exp_pair(i));
      prev_st = m_st;
    end
  end

  // runt monitor: every driven low phase of pair 0 lasts HALF cycles
  int lowrun = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (true_oe_o[0] && !true_val_o[0]) lowrun++;
      else if (lowrun != 0) begin
        n_vec++;
        if (lowrun != HALF) begin
          n_bad++;
          $display("FAIL R3/R7 low phase width actual %0d expected %0d", lowrun, HALF);
        end
        lowrun = 0;
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  int toggles;
  logic last_t;

  initial begin
    // R9: reset state
    #3;
    check("R9", act_pair(0), 4'b1100);
    park_float = 1'b1; #1;
    check("R9", act_pair(1), 4'b0000);
    park_float = 1'b0;
    step(); step();
    rst_n = 1'b1;
    // R1: stays parked through the synchronizer latency
    for (int k = 0; k < SYNC; k++) begin
      @(negedge clk);
      check("R1", act_pair(2), 4'b1100);
    end
    repeat (20) step();
    // R2: a request seen by only one complement rising edge is ignored
    pd_req_n = 1'b0; repeat (3) step(); pd_req_n = 1'b1;
    toggles = 0; last_t = true_val_o[0];
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (true_val_o[0] != last_t) toggles++;
      last_t = true_val_o[0];
    end
    n_vec++;
    if (toggles < 8) begin
      n_bad++;
      $display("FAIL R2 toggles after short request actual %0d expected >= 8", toggles);
    end
    // directed stop/restart in each parking style
    for (int m = 0; m < 2; m++) begin
      step(); park_float = m[0];
      pd_req_n = 1'b0; repeat (30) step();
      pd_req_n = 1'b1; repeat (30) step();
    end
    // random phase
    void'($urandom(32'h5eed_c10c));
    for (int k = 0; k < 600; k++) begin
      int len;
      len = 1 + ($urandom % 16);
      pd_req_n = $urandom % 3 != 0;
      if ($urandom % 5 == 0) park_float = $urandom % 2;
      if ($urandom % 4 == 0) out_en = N'($urandom);
      repeat (len) step();
    end
    step();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule